// File: doc/BRIEF.md
# Multi-Bank Interrupt Control Unit

This block gathers up to 160 peripheral interrupt lines in five banks of 32 and drives one interrupt output per bank toward a processor. For each line it holds a pending bit that a rising edge on the hardware input sets. Software can also set a pending bit through a request register, and it clears a pending bit by writing a one to it. A per-line enable decides whether a pending line counts toward its bank output.

Software reaches every bank through one 32-bit register bus with single-cycle writes and combinational reads. A read-only vector word gives, for each bank, the index plus one of the lowest-numbered line that is both pending and enabled, so a handler can find its source with one read and no bit scan. A field value of zero means the bank has nothing to service.

Top module: `mbank_irq_ctrl`

## Requirements
- R1: Global line n enters on `irq_in[n]` and belongs to bank n/32 at bit n%32 of that bank's registers.
- R2: Writing the pending register of a bank (offset 0x0 in the bank) clears exactly the bits written as 1. Bits written as 0 keep their value.
- R3: A line counts toward its bank's output and vector field only when its enable bit (bank offset 0x4, read/write) is 1.
- R4: Writing 1 to a bit of the request register (bank offset 0x8) sets the matching pending bit. Bits written as 0 have no effect. The register reads as 0.
- R5: The active register (bank offset 0xC, read-only) reads as pending AND enable.
- R6: The vector word at offset 0xC8 holds one 6-bit field per bank at bits [6b+5:6b]. The field equals the lowest set bit index of the bank's active register plus one (1..32), or 0 when no bit is active. Bits 31:30 read as 0.
- R7: `bank_irq[b]` is the OR of bank b's active bits, registered: it changes on the clock edge after the edge that changed the active bits.
- R8: A 0-to-1 transition of a hardware line sets its pending bit on the next edge. A line that stays high does not set the bit again after the bit is cleared.
- R9: When a hardware rising edge and a clear write for the same bit fall on the same edge, the bit ends up set.
- R10: Banks sit at a stride of 0x28 (bases 0x00, 0x28, 0x50, 0x78, 0xA0). Reads of unmapped addresses return 0. Writes to the active or vector registers change nothing.
- R11: Clearing every enable and writing all ones to every pending register deasserts all bank outputs and zeroes the vector word.
- R12: After reset every pending, enable and output bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 160 | Raw interrupt lines, synchronous to clk |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| bank_irq | output | 5 | Registered per-bank interrupt outputs |

## Verification
The case that is hardest to reach from the ports is a hardware edge and a software clear of the same bit landing on one clock edge. The bench handles this by changing the input line and starting the clear write in the same half cycle, after it has first made the line low so that a real edge follows. A second hard case is a line held high after it has been cleared, which shows that setting responds to edges and not to levels. The registered output is checked on both sides of its one-cycle delay.

// File: rtl/icu_pkg.sv
package icu_pkg;
  // per-bank register offsets
  localparam logic [7:0] OFS_PEND   = 8'h00;
  localparam logic [7:0] OFS_ENABLE = 8'h04;
  localparam logic [7:0] OFS_RAISE  = 8'h08;
  localparam logic [7:0] OFS_ACTIVE = 8'h0C;

  // write strobes delivered to one bank
  typedef struct packed {
    logic clr;
    logic ena;
    logic raise;
  } bank_wr_t;
endpackage

// File: rtl/icu_edge_det.sv
module icu_edge_det #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q, prev_d;

  always_comb prev_d = line_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  assign rise_o = line_i & ~prev_q;
endmodule

// File: rtl/icu_prio_enc.sv
module icu_prio_enc #(
  parameter int unsigned N  = 32,
  parameter int unsigned IW = 6
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] code_o
);
  // lowest-numbered request wins; code is index + 1, zero when idle
  always_comb begin
    code_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) code_o = IW'(i + 1);
    end
  end
endmodule

// File: rtl/icu_bank.sv
module icu_bank
  import icu_pkg::*;
#(
  parameter int unsigned N  = 32,
  parameter int unsigned IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  line_i,
  input  bank_wr_t      wr_i,
  input  logic [N-1:0]  wdata_i,
  output logic [N-1:0]  pend_o,
  output logic [N-1:0]  enable_o,
  output logic [N-1:0]  active_o,
  output logic [IW-1:0] code_o,
  output logic          irq_o
);
  logic [N-1:0] pend_q, pend_d;
  logic [N-1:0] en_q, en_d;
  logic         irq_q, irq_d;
  logic [N-1:0] rise;
  logic [N-1:0] clr_mask, set_mask;
  logic [N-1:0] active;

  icu_edge_det #(.N(N)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (line_i),
    .rise_o (rise)
  );

  assign active = pend_q & en_q;

  icu_prio_enc #(.N(N), .IW(IW)) u_enc (
    .req_i  (active),
    .code_o (code_o)
  );

  // next state: hardware and software sets override a concurrent clear
  always_comb begin
    clr_mask = wr_i.clr   ? wdata_i : '0;
    set_mask = wr_i.raise ? wdata_i : '0;
    pend_d   = (pend_q & ~clr_mask) | rise | set_mask;
    en_d     = wr_i.ena ? wdata_i : en_q;
    irq_d    = |active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (wr_i.ena) en_q <= en_d;
      irq_q  <= irq_d;
    end
  end

  assign pend_o   = pend_q;
  assign enable_o = en_q;
  assign active_o = active;
  assign irq_o    = irq_q;

  // R2: written ones are gone after a clear unless an edge fired
  assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i.clr && !wr_i.raise) |=> ((pend_q & $past(wdata_i) & ~$past(rise)) == '0));
  // R4: request-set raises every written one
  assert_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i.raise |=> (($past(wdata_i) & ~pend_q) == '0));
  // R9: a hardware edge is never lost
  assert_edge_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> (($past(rise) & ~pend_q) == '0));
  // R7: output follows the active set one edge later
  assert_out_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|active) |=> irq_q);
  assert_out_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|active) |=> !irq_q);
  // R6: vector code points at the lowest active line
  assert_vec_lowest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o != '0) |-> (active[code_o - 1'b1] &&
      ((active & ((N'(1) << (code_o - 1'b1)) - N'(1))) == '0)));
  assert_vec_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o == '0) |-> (active == '0));
endmodule

// File: rtl/mbank_irq_ctrl.sv
module mbank_irq_ctrl
  import icu_pkg::*;
#(
  parameter int unsigned NUM_BANKS      = 5,
  parameter int unsigned LINES_PER_BANK = 32,
  parameter int unsigned ADDR_W         = 8,
  parameter int unsigned BANK_STRIDE    = 40
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_BANKS*LINES_PER_BANK-1:0] irq_in,
  input  logic                                reg_en,
  input  logic                                reg_we,
  input  logic [ADDR_W-1:0]                   reg_addr,
  input  logic [LINES_PER_BANK-1:0]           reg_wdata,
  output logic [LINES_PER_BANK-1:0]           reg_rdata,
  output logic [NUM_BANKS-1:0]                bank_irq
);
  localparam int unsigned N        = LINES_PER_BANK;
  localparam int unsigned IW       = $clog2(N) + 1;
  localparam int unsigned VEC_W    = NUM_BANKS * IW;
  localparam int unsigned VEC_ADDR = NUM_BANKS * BANK_STRIDE;

  logic [N-1:0]     pend_a   [NUM_BANKS];
  logic [N-1:0]     en_a     [NUM_BANKS];
  logic [N-1:0]     act_a    [NUM_BANKS];
  logic [IW-1:0]    code_a   [NUM_BANKS];
  bank_wr_t         wr_a     [NUM_BANKS];
  logic [VEC_W-1:0] vec;
  logic             wr_go;

  assign wr_go = reg_en & reg_we;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned BASE = b * BANK_STRIDE;

    always_comb begin
      wr_a[b].clr   = wr_go && (reg_addr == ADDR_W'(BASE + OFS_PEND));
      wr_a[b].ena   = wr_go && (reg_addr == ADDR_W'(BASE + OFS_ENABLE));
      wr_a[b].raise = wr_go && (reg_addr == ADDR_W'(BASE + OFS_RAISE));
    end

    icu_bank #(.N(N), .IW(IW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_i   (irq_in[b*N +: N]),
      .wr_i     (wr_a[b]),
      .wdata_i  (reg_wdata),
      .pend_o   (pend_a[b]),
      .enable_o (en_a[b]),
      .active_o (act_a[b]),
      .code_o   (code_a[b]),
      .irq_o    (bank_irq[b])
    );

    assign vec[b*IW +: IW] = code_a[b];
  end

  // read mux; unmapped and write-only locations return zero
  always_comb begin
    reg_rdata = '0;
    if (reg_en && !reg_we) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (reg_addr == ADDR_W'(b * BANK_STRIDE + OFS_PEND))   reg_rdata = pend_a[b];
        if (reg_addr == ADDR_W'(b * BANK_STRIDE + OFS_ENABLE)) reg_rdata = en_a[b];
        if (reg_addr == ADDR_W'(b * BANK_STRIDE + OFS_ACTIVE)) reg_rdata = act_a[b];
      end
      if (reg_addr == ADDR_W'(VEC_ADDR)) reg_rdata[VEC_W-1:0] = vec;
    end
  end

  // R10: at most one bank strobe per write
  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_a[0], wr_a[1], wr_a[2], wr_a[3], wr_a[4]}));
  // R11: with every enable clear no bank output rises
  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ({en_a[0], en_a[1], en_a[2], en_a[3], en_a[4]} == '0) |=> (bank_irq == '0));
endmodule

// File: tb/tb_mbank_irq_ctrl.sv
module tb_mbank_irq_ctrl;
  localparam int NB = 5;
  localparam int NL = 32;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NB*NL-1:0] irq_in;
  logic           reg_en, reg_we;
  logic [7:0]     reg_addr;
  logic [31:0]    reg_wdata;
  logic [31:0]    reg_rdata;
  logic [NB-1:0]  bank_irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  mbank_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bank_irq(bank_irq)
  );

  function automatic logic [7:0] base(int b);
    return 8'(b * 40);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_en = 1; reg_we = 0; reg_addr = a;
    #1 d = reg_rdata;
    reg_en = 0;
  endtask

  task automatic quiet_all();
    for (int b = 0; b < NB; b++) begin
      wr(base(b) + 8'h4, 32'h0);
      wr(base(b) + 8'h0, 32'hFFFF_FFFF);
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int b = 0; b < NB; b++) begin
      rd(base(b), d);        check("R12 pending", d, 0);
      rd(base(b) + 8'h4, d); check("R12 enable", d, 0);
    end
    check("R12 outputs", 32'(bank_irq), 0);
  endtask

  task automatic t_mapping();
    logic [31:0] d;
    @(negedge clk); irq_in[37] = 1; irq_in[159] = 1;
    @(negedge clk);
    rd(base(1), d); check("R1 line37", d, 32'h20);
    rd(base(4), d); check("R1 line159", d, 32'h8000_0000);
    rd(base(0), d); check("R1 bank0 untouched", d, 0);
    irq_in = '0;
    quiet_all();
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(base(2) + 8'h8, 32'hF0F0_00FF);
    wr(base(2), 32'h0000_0F0F);
    rd(base(2), d); check("R2 partial clear", d, 32'hF0F0_00F0);
    wr(base(2), 32'h0);
    rd(base(2), d); check("R2 zero write keeps", d, 32'hF0F0_00F0);
    quiet_all();
  endtask

  task automatic t_raise();
    logic [31:0] d;
    wr(base(3) + 8'h8, 32'h0000_0011);
    wr(base(3) + 8'h8, 32'h0000_0000);
    rd(base(3), d);        check("R4 set and zero write", d, 32'h11);
    rd(base(3) + 8'h8, d); check("R4 reads zero", d, 0);
    quiet_all();
  endtask

  task automatic t_enable_active();
    logic [31:0] d;
    wr(base(0) + 8'h8, 32'h0000_00F0);
    wr(base(0) + 8'h4, 32'h0000_0330);
    rd(base(0) + 8'hC, d); check("R5 active", d, 32'h30);
    rd(base(0) + 8'h4, d); check("R3 enable readback", d, 32'h330);
    wr(base(0) + 8'h4, 32'h0000_0003);
    @(negedge clk);
    rd(base(0) + 8'hC, d); check("R3 disabled gives no active", d, 0);
    check("R3 disabled output low", 32'(bank_irq[0]), 0);
    quiet_all();
  endtask

  task automatic t_latency();
    wr(base(1) + 8'h4, 32'h1);
    wr(base(1) + 8'h8, 32'h1);
    check("R7 not yet", 32'(bank_irq[1]), 0);
    @(negedge clk);
    check("R7 one edge later", 32'(bank_irq[1]), 1);
    wr(base(1), 32'h1);
    check("R7 still high", 32'(bank_irq[1]), 1);
    @(negedge clk);
    check("R7 falls", 32'(bank_irq[1]), 0);
    quiet_all();
  endtask

  task automatic t_vector();
    logic [31:0] d;
    logic [31:0] exp;
    wr(base(2) + 8'h8, 32'h0000_0088);
    wr(base(2) + 8'h4, 32'hFFFF_FFFF);
    wr(base(4) + 8'h8, 32'h8000_0000);
    wr(base(4) + 8'h4, 32'h8000_0000);
    wr(base(1) + 8'h8, 32'h0000_0001);
    exp = (32'd4 << 12) | (32'd32 << 24);
    rd(8'hC8, d); check("R6 vector lowest/edge/none", d, exp);
    wr(base(1) + 8'h4, 32'h1);
    exp = exp | (32'd1 << 6);
    rd(8'hC8, d); check("R6 vector bit0 gives 1", d, exp);
    quiet_all();
  endtask

  task automatic t_level();
    logic [31:0] d;
    @(negedge clk); irq_in[70] = 1;
    @(negedge clk);
    rd(base(2), d); check("R8 edge sets", d, 32'h40);
    wr(base(2), 32'h40);
    @(negedge clk); @(negedge clk);
    rd(base(2), d); check("R8 held level no reset", d, 0);
    irq_in = '0;
    quiet_all();
  endtask

  task automatic t_collision();
    logic [31:0] d;
    wr(base(3) + 8'h8, 32'h4);
    @(negedge clk);
    irq_in[3*32+2] = 1;
    reg_en = 1; reg_we = 1; reg_addr = base(3); reg_wdata = 32'h4;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
    rd(base(3), d); check("R9 edge beats clear", d, 32'h4);
    irq_in = '0;
    quiet_all();
  endtask

  task automatic t_map_ro();
    logic [31:0] d;
    wr(base(0) + 8'h8, 32'h5);
    wr(base(0) + 8'hC, 32'hFFFF_FFFF);
    wr(8'hC8, 32'hFFFF_FFFF);
    rd(base(0), d);        check("R10 ro write ignored", d, 32'h5);
    rd(base(0) + 8'h4, d); check("R10 enable untouched", d, 0);
    rd(8'h10, d);          check("R10 unmapped", d, 0);
    rd(8'hCC, d);          check("R10 past vector", d, 0);
    wr(8'h50 + 8'h8, 32'h2);
    rd(8'h50, d);          check("R10 bank2 base", d, 32'h2);
    quiet_all();
  endtask

  task automatic t_quiet();
    logic [31:0] d;
    for (int b = 0; b < NB; b++) begin
      wr(base(b) + 8'h8, 32'hFFFF_FFFF);
      wr(base(b) + 8'h4, 32'hFFFF_FFFF);
    end
    @(negedge clk);
    check("R11 all up", 32'(bank_irq), 32'h1F);
    quiet_all();
    @(negedge clk);
    check("R11 all down", 32'(bank_irq), 0);
    rd(8'hC8, d); check("R11 vector zero", d, 0);
  endtask

  initial begin
    irq_in = '0; reg_en = 0; reg_we = 0; reg_addr = '0; reg_wdata = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mapping();
    t_w1c();
    t_raise();
    t_enable_active();
    t_latency();
    t_vector();
    t_level();
    t_collision();
    t_map_ro();
    t_quiet();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule